// File: doc/BRIEF.md
# Serial-Parallel Binary Multiplier

This block multiplies two unsigned integers. The N-bit factor is applied on a parallel bus and captured when a job is accepted. The M-bit factor arrives on a one-bit input, least significant bit first. The product leaves on a one-bit output, also least significant bit first, one bit per clock, with a valid flag around it.

The datapath is a row of N identical slices. Each slice forms the AND of a multiplicand bit with its own factor bit and adds it in a full adder. The carry of that adder is held in a per-slice register. A compile-time parameter picks the slice interconnect:
- In the plain structure, the multiplicand is delayed by one register per slice, and sums ripple combinationally from the top slice down to slice 0. The critical path is therefore N-1 adders.
- In the pipelined structure, the multiplicand bit is broadcast to all slices and every inter-slice sum is registered. Each column of the product is then formed over N-1 cycles while a new column starts every cycle, so the critical path is one adder.

Both structures give identical port timing. Once all M multiplicand bits are in, the block feeds zeros internally so that the carries held in the slices flush into the upper product bits. Every carry, sum and delay register is cleared when a job is accepted.

Top module: `serpar_mult`

## Requirements
- R1: The 2-input product of the captured factor and the serial multiplicand appears on `z_bit` least significant bit first, with the bit of weight 2^k present in the cycle k+2 after the accepting edge (cycle 1 is the first cycle after that edge).
- R2: `x_take` is high in cycles 1 to M after the accepting edge and low otherwise. The bit of weight 2^k is sampled from `x_bit` in cycle k+1.
- R3: While `x_take` is low, `x_bit` has no effect: the block multiplies as if zeros followed the M multiplicand bits.
- R4: `z_valid` is high for exactly M+N consecutive cycles, namely cycles 2 to M+N+1.
- R5: `done` is a single-cycle pulse in cycle M+N+2, the cycle after the last valid product bit.
- R6: `start` is accepted only while `busy` is low. `busy` is high in cycles 1 to M+N. A `start` raised while busy has no effect on the running job.
- R7: `y_in` is captured at the accepting edge. Changes of `y_in` during a job do not alter its product.
- R8: A job accepted in the cycle that carries the previous job's last product bit gives a correct product. No carry or sum state carries over between jobs.
- R9: After reset, `busy`, `x_take`, `z_valid`, `z_bit` and `done` are 0.
- R10: The plain (PIPELINED=0) and pipelined (PIPELINED=1) structures give identical port behaviour for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new job; accepted when idle |
| y_in | input | N_BITS | Parallel factor, captured on acceptance |
| x_bit | input | 1 | Serial multiplicand bit, LSB first |
| x_take | output | 1 | High when `x_bit` is sampled this cycle |
| busy | output | 1 | Job in progress |
| z_bit | output | 1 | Serial product bit, LSB first |
| z_valid | output | 1 | `z_bit` holds a product bit |
| done | output | 1 | One-cycle pulse after the last product bit |

## Verification
On every cycle, the assertions check the handshake framing: that `x_take` only occurs while busy, that every valid burst is exactly M+N cycles long, that `done` is a lone pulse directly after a burst, and that busy only rises from an accepted start. Only the bench scenarios can show the arithmetic itself. These scenarios cover extreme operands, stray ones on `x_bit` after the intake window, a factor bus that changes mid-job, starts during a job, and jobs run back to back. Both structures run side by side and are compared against the same cycle-exact model.

// File: rtl/smul_pkg.sv
package smul_pkg;
   typedef enum logic {
      SM_IDLE = 1'b0,
      SM_RUN  = 1'b1
   } smul_state_e;

   function automatic int smul_cnt_w(input int total);
      return (total < 2) ? 1 : $clog2(total + 1);
   endfunction
endpackage

// File: rtl/smul_slice.sv
module smul_slice #(
   parameter bit REG_SUM = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic x_i,
   input  logic y_i,
   input  logic sum_i,
   output logic sum_o
);
   logic pp;
   logic s;
   logic co;
   logic carry_q;

   // AND gate feeding a full adder whose carry is kept per slice
   assign pp = x_i & y_i;
   assign s  = pp ^ sum_i ^ carry_q;
   assign co = (pp & sum_i) | (pp & carry_q) | (sum_i & carry_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   carry_q <= 1'b0;
      else if (clr) carry_q <= 1'b0;
      else if (en)  carry_q <= co;
   end

   generate
      if (REG_SUM) begin : g_reg
         logic sum_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   sum_q <= 1'b0;
            else if (clr) sum_q <= 1'b0;
            else if (en)  sum_q <= s;
         end
         assign sum_o = sum_q;
      end else begin : g_comb
         assign sum_o = s;
      end
   endgenerate
endmodule

// File: rtl/smul_xline.sv
module smul_xline #(
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             x_i,
   output logic [DEPTH-1:0] tap_o
);
   assign tap_o[0] = x_i;

   generate
      for (genvar j = 1; j < DEPTH; j++) begin : g_stage
         logic d_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   d_q <= 1'b0;
            else if (clr) d_q <= 1'b0;
            else if (en)  d_q <= tap_o[j-1];
         end
         assign tap_o[j] = d_q;
      end
   endgenerate
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
   import smul_pkg::*;
#(
   parameter int M_BITS = 8,
   parameter int N_BITS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic accept,
   output logic busy,
   output logic x_take,
   output logic last
);
   localparam int TOTAL = M_BITS + N_BITS;
   localparam int CW    = smul_cnt_w(TOTAL);

   smul_state_e state_q;
   logic [CW-1:0] cnt_q;

   assign busy   = (state_q == SM_RUN);
   assign accept = start & ~busy;
   assign x_take = busy & (cnt_q < CW'(M_BITS));
   assign last   = busy & (cnt_q == CW'(TOTAL - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SM_IDLE;
         cnt_q   <= '0;
      end else if (accept) begin
         state_q <= SM_RUN;
         cnt_q   <= '0;
      end else if (busy) begin
         if (last) state_q <= SM_IDLE;
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/serpar_mult.sv
module serpar_mult #(
   parameter int M_BITS    = 8,
   parameter int N_BITS    = 8,
   parameter bit PIPELINED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [N_BITS-1:0] y_in,
   input  logic              x_bit,
   output logic              x_take,
   output logic              busy,
   output logic              z_bit,
   output logic              z_valid,
   output logic              done
);
   generate
      if (M_BITS < 1) begin : g_bad_m
         $error("serpar_mult: M_BITS must be at least 1");
      end
      if (N_BITS < 1) begin : g_bad_n
         $error("serpar_mult: N_BITS must be at least 1");
      end
   endgenerate

   logic              accept;
   logic              last;
   logic              x_eff;
   logic [N_BITS-1:0] y_q;
   logic [N_BITS-1:0] x_tap;
   logic [N_BITS:0]   sums;
   logic              z_q, zv_q, zlast_q, done_q;

   smul_ctrl #(.M_BITS(M_BITS), .N_BITS(N_BITS)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .accept (accept),
      .busy   (busy),
      .x_take (x_take),
      .last   (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      y_q <= '0;
      else if (accept) y_q <= y_in;
   end

   // zeros replace the serial input once the intake window closes
   assign x_eff = x_take & x_bit;

   generate
      if (PIPELINED) begin : g_bcast
         assign x_tap = {N_BITS{x_eff}};
      end else begin : g_delay
         smul_xline #(.DEPTH(N_BITS)) u_xline (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (accept),
            .en    (busy),
            .x_i   (x_eff),
            .tap_o (x_tap)
         );
      end
   endgenerate

   assign sums[N_BITS] = 1'b0;

   generate
      for (genvar j = 0; j < N_BITS; j++) begin : g_slice
         smul_slice #(.REG_SUM(PIPELINED && (j > 0))) u_slice (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (accept),
            .en    (busy),
            .x_i   (x_tap[j]),
            .y_i   (y_q[j]),
            .sum_i (sums[j+1]),
            .sum_o (sums[j])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         z_q     <= 1'b0;
         zv_q    <= 1'b0;
         zlast_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         if (busy) z_q <= sums[0];
         zv_q    <= busy;
         zlast_q <= last;
         done_q  <= zv_q & zlast_q;
      end
   end

   assign z_bit   = z_q;
   assign z_valid = zv_q;
   assign done    = done_q;
endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
   parameter int M_BITS = 8,
   parameter int N_BITS = 8
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic x_take,
   input logic z_valid,
   input logic done
);
   localparam int TOTAL = M_BITS + N_BITS;
   localparam int LW    = $clog2(TOTAL + 2);

   logic [LW-1:0] run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_len <= '0;
      else if (z_valid) run_len <= run_len + 1'b1;
      else              run_len <= '0;
   end

   // R2
   take_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      x_take |-> busy);

   // R4
   burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(z_valid) |-> (run_len == LW'(TOTAL)));

   // R4
   burst_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      z_valid |-> (run_len < LW'(TOTAL)));

   // R5
   done_after_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!z_valid && $past(z_valid)));

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

bind serpar_mult smul_chk #(.M_BITS(M_BITS), .N_BITS(N_BITS)) u_smul_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .x_take  (x_take),
   .z_valid (z_valid),
   .done    (done)
);

// File: tb/tb_serpar_mult.sv
module tb_serpar_mult;
   localparam int M = 8;
   localparam int N = 8;
   localparam int P = M + N;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [N-1:0] y_in = '0;
   logic x_bit = 1'b0;
   logic xt_a, bz_a, z_a, zv_a, dn_a;
   logic xt_b, bz_b, z_b, zv_b, dn_b;
   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   serpar_mult #(.M_BITS(M), .N_BITS(N), .PIPELINED(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .y_in(y_in), .x_bit(x_bit),
      .x_take(xt_a), .busy(bz_a), .z_bit(z_a), .z_valid(zv_a), .done(dn_a));

   // R10: pipelined structure, same stimulus and same expectations
   serpar_mult #(.M_BITS(M), .N_BITS(N), .PIPELINED(1'b1)) dut_p (
      .clk(clk), .rst_n(rst_n), .start(start), .y_in(y_in), .x_bit(x_bit),
      .x_take(xt_b), .busy(bz_b), .z_bit(z_b), .z_valid(zv_b), .done(dn_b));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks = checks + 1;
      if (act != exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_both(input string req, input logic a, input logic b, input logic exp);
      chk({req, " plain"}, int'(a), int'(exp));
      chk({req, " pipe R10"}, int'(b), int'(exp));
   endtask

   // One job checked cycle by cycle. chained: job accepted in the previous
   // job's last valid cycle. chain_next: raise start for a follow-on job.
   task automatic do_run(input logic [M-1:0] xv, input logic [N-1:0] yv,
                         input bit chained, input bit chain_next,
                         input logic [N-1:0] ny, input bit disturb);
      logic [P-1:0] prod;
      prod = P'(xv) * P'(yv);
      if (!chained) begin
         @(negedge clk);
         start = 1'b1;
         y_in  = yv;
      end
      for (int i = 1; i <= P + 1; i++) begin
         @(negedge clk);
         start = 1'b0;
         if (disturb) begin
            y_in = ~yv;                          // R7
            if (i == 3 || i == P) start = 1'b1;  // R6
         end
         chk_both("R6 busy", bz_a, bz_b, i <= P);
         chk_both("R2 x_take", xt_a, xt_b, i <= M);
         chk_both("R4 z_valid", zv_a, zv_b, i >= 2);
         chk_both("R5 done", dn_a, dn_b, (i == 1) && chained);
         if (i >= 2) chk_both("R1 z_bit", z_a, z_b, prod[i-2]);
         x_bit = (i <= M) ? xv[i-1] : 1'b1;      // R3: stray ones after intake
         if (i == P + 1 && chain_next) begin
            start = 1'b1;                        // R8
            y_in  = ny;
         end
      end
      if (!chain_next) begin
         @(negedge clk);
         start = 1'b0;
         chk_both("R5 done pulse", dn_a, dn_b, 1'b1);
         chk_both("R4 z_valid end", zv_a, zv_b, 1'b0);
         chk_both("R6 idle", bz_a, bz_b, 1'b0);
         @(negedge clk);
         chk_both("R5 done single", dn_a, dn_b, 1'b0);
      end
   endtask

   initial begin
      #1;
      // R9: reset values
      chk_both("R9 busy", bz_a, bz_b, 1'b0);
      chk_both("R9 x_take", xt_a, xt_b, 1'b0);
      chk_both("R9 z_valid", zv_a, zv_b, 1'b0);
      chk_both("R9 z_bit", z_a, z_b, 1'b0);
      chk_both("R9 done", dn_a, dn_b, 1'b0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_both("R9 idle after reset", bz_a, bz_b, 1'b0);

      do_run(8'd0,   8'd0,   1'b0, 1'b0, '0, 1'b0);  // R1
      do_run(8'hFF,  8'hFF,  1'b0, 1'b0, '0, 1'b0);  // R1 R3 full carries
      do_run(8'd1,   8'd1,   1'b0, 1'b0, '0, 1'b0);
      do_run(8'h80,  8'h01,  1'b0, 1'b0, '0, 1'b0);
      do_run(8'h01,  8'h80,  1'b0, 1'b0, '0, 1'b0);
      do_run(8'hA5,  8'h3C,  1'b0, 1'b0, '0, 1'b1);  // R6 R7 disturbance
      // R8: back-to-back jobs, first leaves carries set
      do_run(8'hFF,  8'hFF,  1'b0, 1'b1, 8'h01, 1'b0);
      do_run(8'h01,  8'h01,  1'b1, 1'b1, 8'hC3, 1'b0);
      do_run(8'h7E,  8'hC3,  1'b1, 1'b0, '0, 1'b0);
      for (int k = 0; k < 6; k++) begin
         logic [M-1:0] rx;
         logic [N-1:0] ry;
         rx = M'($urandom);
         ry = N'($urandom);
         do_run(rx, ry, 1'b0, 1'b0, '0, k[0]);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule